// File: doc/BRIEF.md
# UART Interrupt Status and Routing

This block holds the interrupt state of a serial port. Eleven sources (receive, transmit, receive timeout, four modem-status changes and four line errors) each deliver a one-cycle set pulse. Each pulse latches a sticky bit in a raw status word. A software-writable enable mask gates the raw word into a masked status word. That masked word is fanned out to six registered interrupt lines: one combined line and five group lines.

Software reaches the block through a plain register port with valid, write, address and data signals. Reads of the selected register are combinational. Writes take effect at the clock edge. The port decodes four word addresses:

| Address | Register | Access |
|---|---|---|
| 0 | Raw status | Read only |
| 1 | Masked status | Read only |
| 2 | Enable mask | Read and write |
| 3 | Clear | Write only; writing a 1 to a bit clears that raw status bit |

Any other address reads as zero, and writes to it are dropped.

Top module: `uart_irq_router`

## Requirements
- R1: After reset the raw status, the enable mask and the masked status all read 0, and all six interrupt lines are low.
- R2: Each set pulse sets one raw status bit, at this bit position: ring indicator 0, CTS 1, DCD 2, DSR 3, receive 4, transmit 5, receive timeout 6, framing 7, parity 8, break 9, overrun 10. The ports map as follows: `ms_evt[3:0]` drives bits 3..0, `rx_evt` drives bit 4, `tx_evt` drives bit 5, `rto_evt` drives bit 6, and `err_evt[3:0]` drives bits 10..7.
- R3: A write to address 3 clears every raw bit whose data bit is 1. Raw bits written as 0 keep their value.
- R4: When a set pulse and a clear write hit the same bit in one cycle, the bit ends up set.
- R5: The enable mask at address 2 reads back exactly the last 11-bit value written to it.
- R6: A read of address 1 returns the raw status ANDed with the enable mask.
- R7: The combined line `irq_any` is high when any bit of the masked status is set.
- R8: The group lines follow the masked status: `irq_rx` follows bit 4, `irq_tx` follows bit 5, `irq_rto` follows bit 6, `irq_ms` is the OR of bits 3..0, and `irq_err` is the OR of bits 10..7.
- R9: Each interrupt line changes one clock cycle after the raw status or mask update that causes the change.
- R10: Writes to address 0 or address 1 leave the raw status and the enable mask unchanged.
- R11: A raw status bit stays set until it is cleared through address 3, even after its source pulse has ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_evt | input | 1 | Receive event set pulse |
| tx_evt | input | 1 | Transmit event set pulse |
| rto_evt | input | 1 | Receive timeout set pulse |
| ms_evt | input | 4 | Modem-status set pulses (ring indicator, CTS, DCD, DSR) |
| err_evt | input | 4 | Error set pulses (framing, parity, break, overrun) |
| req_valid | input | 1 | Register access strobe |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | ADDR_W | Register word address |
| req_wdata | input | 11 | Write data |
| rsp_rdata | output | 11 | Read data for the addressed register (combinational) |
| irq_any | output | 1 | Combined interrupt line |
| irq_rx | output | 1 | Receive interrupt line |
| irq_tx | output | 1 | Transmit interrupt line |
| irq_rto | output | 1 | Receive timeout interrupt line |
| irq_ms | output | 1 | Modem-status interrupt line |
| irq_err | output | 1 | Error interrupt line |

## Verification
The hardest case to reach from the ports is a set pulse and a clear write landing on the same status bit in the same clock cycle. The bench reaches it by driving a source pulse and a clear write with that bit's data bit at 1 on the same falling edge, then reading the raw status back.

Register latency is checked by sampling each interrupt line twice after an update. The first sample is taken one half-cycle after the update and must still show the old level. The second is taken one cycle later and must show the new level.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int NSRC  = 11;
  localparam int NLINE = 6;

  typedef logic [NSRC-1:0] src_vec_t;

  // Source bit positions
  localparam int B_RING  = 0;
  localparam int B_CTS   = 1;
  localparam int B_DCD   = 2;
  localparam int B_DSR   = 3;
  localparam int B_RX    = 4;
  localparam int B_TX    = 5;
  localparam int B_RTO   = 6;
  localparam int B_FRAME = 7;
  localparam int B_PAR   = 8;
  localparam int B_BRK   = 9;
  localparam int B_OVR   = 10;

  // Line indices
  localparam int LN_ANY = 0;
  localparam int LN_RX  = 1;
  localparam int LN_TX  = 2;
  localparam int LN_RTO = 3;
  localparam int LN_MS  = 4;
  localparam int LN_ERR = 5;

  typedef enum logic [1:0] {
    SEL_RAW    = 2'd0,
    SEL_MASKED = 2'd1,
    SEL_ENABLE = 2'd2,
    SEL_CLEAR  = 2'd3
  } reg_sel_e;

  // Source bits that feed a given line
  function automatic src_vec_t line_sel(input int ln);
    src_vec_t v;
    v = '0;
    case (ln)
      LN_ANY: v = '1;
      LN_RX:  v[B_RX]  = 1'b1;
      LN_TX:  v[B_TX]  = 1'b1;
      LN_RTO: v[B_RTO] = 1'b1;
      LN_MS:  begin
        v[B_RING] = 1'b1; v[B_CTS] = 1'b1; v[B_DCD] = 1'b1; v[B_DSR] = 1'b1;
      end
      LN_ERR: begin
        v[B_FRAME] = 1'b1; v[B_PAR] = 1'b1; v[B_BRK] = 1'b1; v[B_OVR] = 1'b1;
      end
      default: v = '0;
    endcase
    return v;
  endfunction

  // Next raw status: set pulses take priority over the clear
  function automatic src_vec_t raw_next(input src_vec_t cur, input src_vec_t set,
                                        input logic clr, input src_vec_t clr_bits);
    src_vec_t keep;
    keep = clr ? (cur & ~clr_bits) : cur;
    return keep | set;
  endfunction
endpackage

// File: rtl/irq_status_reg.sv
module irq_status_reg
  import uart_irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  src_vec_t set_vec,
  input  logic     clr_en,
  input  src_vec_t clr_bits,
  output src_vec_t raw_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw_q <= '0;
    else        raw_q <= raw_next(raw_q, set_vec, clr_en, clr_bits);
  end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg
  import uart_irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_en,
  input  src_vec_t wr_data,
  output src_vec_t mask_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     mask_q <= '0;
    else if (wr_en) mask_q <= wr_data;
  end
endmodule

// File: rtl/irq_line_drv.sv
module irq_line_drv
  import uart_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  src_vec_t         masked,
  output logic [NLINE-1:0] lines_q
);
  for (genvar ln = 0; ln < NLINE; ln++) begin : g_line
    logic hit;
    assign hit = |(masked & line_sel(ln));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lines_q[ln] <= 1'b0;
      else        lines_q[ln] <= hit;
    end
  end
endmodule

// File: rtl/uart_irq_router.sv
module uart_irq_router
  import uart_irq_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_evt,
  input  logic              tx_evt,
  input  logic              rto_evt,
  input  logic [3:0]        ms_evt,
  input  logic [3:0]        err_evt,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [NSRC-1:0]   req_wdata,
  output logic [NSRC-1:0]   rsp_rdata,
  output logic              irq_any,
  output logic              irq_rx,
  output logic              irq_tx,
  output logic              irq_rto,
  output logic              irq_ms,
  output logic              irq_err
);
  localparam int SEL_W = 2;

  src_vec_t         set_vec;
  src_vec_t         raw_q;
  src_vec_t         mask_q;
  src_vec_t         masked;
  logic             addr_ok;
  reg_sel_e         sel;
  logic             clr_fire;
  logic             mask_wr;
  logic [NLINE-1:0] lines_q;

  assign set_vec = {err_evt, rto_evt, tx_evt, rx_evt, ms_evt};

  assign addr_ok  = (req_addr >> SEL_W) == '0;
  assign sel      = reg_sel_e'(req_addr[SEL_W-1:0]);
  assign clr_fire = req_valid && req_write && addr_ok && (sel == SEL_CLEAR);
  assign mask_wr  = req_valid && req_write && addr_ok && (sel == SEL_ENABLE);

  irq_status_reg u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_vec  (set_vec),
    .clr_en   (clr_fire),
    .clr_bits (req_wdata),
    .raw_q    (raw_q)
  );

  irq_mask_reg u_mask (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (mask_wr),
    .wr_data (req_wdata),
    .mask_q  (mask_q)
  );

  assign masked = raw_q & mask_q;

  irq_line_drv u_lines (
    .clk     (clk),
    .rst_n   (rst_n),
    .masked  (masked),
    .lines_q (lines_q)
  );

  always_comb begin
    rsp_rdata = '0;
    if (req_valid && !req_write && addr_ok) begin
      case (sel)
        SEL_RAW:    rsp_rdata = raw_q;
        SEL_MASKED: rsp_rdata = masked;
        SEL_ENABLE: rsp_rdata = mask_q;
        default:    rsp_rdata = '0;
      endcase
    end
  end

  assign irq_any = lines_q[LN_ANY];
  assign irq_rx  = lines_q[LN_RX];
  assign irq_tx  = lines_q[LN_TX];
  assign irq_rto = lines_q[LN_RTO];
  assign irq_ms  = lines_q[LN_MS];
  assign irq_err = lines_q[LN_ERR];
endmodule

// File: rtl/uart_irq_chk.sv
module uart_irq_chk
  import uart_irq_pkg::*;
(
  input logic     clk,
  input logic     rst_n,
  input src_vec_t set_vec,
  input logic     clr_fire,
  input src_vec_t clr_bits,
  input src_vec_t raw_q,
  input src_vec_t mask_q,
  input logic     irq_any,
  input logic     irq_rx,
  input logic     irq_ms,
  input logic     irq_err
);
  a_r1_reset_clears: assert property (@(posedge clk)
    !rst_n |=> (raw_q == '0 && mask_q == '0));

  a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    |set_vec |=> ((raw_q & $past(set_vec)) == $past(set_vec)));

  a_r3_clear_ones: assert property (@(posedge clk) disable iff (!rst_n)
    clr_fire |=> ((raw_q & $past(clr_bits) & ~$past(set_vec)) == '0));

  a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_fire |=> ((raw_q & $past(raw_q)) == $past(raw_q)));

  a_r7_any_latency: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (irq_any == |($past(raw_q) & $past(mask_q))));

  a_r8_err_group: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (irq_err == |($past(raw_q[10:7]) & $past(mask_q[10:7]))));

  a_r8_ms_group: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (irq_ms == |($past(raw_q[3:0]) & $past(mask_q[3:0]))));

  a_r9_rx_latency: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (irq_rx == ($past(raw_q[4]) & $past(mask_q[4]))));
endmodule

bind uart_irq_router uart_irq_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .set_vec  (set_vec),
  .clr_fire (clr_fire),
  .clr_bits (req_wdata),
  .raw_q    (raw_q),
  .mask_q   (mask_q),
  .irq_any  (irq_any),
  .irq_rx   (irq_rx),
  .irq_ms   (irq_ms),
  .irq_err  (irq_err)
);

// File: tb/sim_uart_irq_router.sv
module sim_uart_irq_router;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_evt = 1'b0, tx_evt = 1'b0, rto_evt = 1'b0;
  logic [3:0]  ms_evt = '0, err_evt = '0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [3:0]  req_addr = '0;
  logic [10:0] req_wdata = '0;
  logic [10:0] rsp_rdata;
  logic        irq_any, irq_rx, irq_tx, irq_rto, irq_ms, irq_err;

  int checks = 0;
  int errors = 0;
  logic [10:0] exp_raw = '0;
  logic [10:0] exp_mask = '0;

  always #4 clk = ~clk;

  uart_irq_router #(.ADDR_W(4)) u0 (
    .clk(clk), .rst_n(rst_n), .rx_evt(rx_evt), .tx_evt(tx_evt), .rto_evt(rto_evt),
    .ms_evt(ms_evt), .err_evt(err_evt), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
    .irq_any(irq_any), .irq_rx(irq_rx), .irq_tx(irq_tx), .irq_rto(irq_rto),
    .irq_ms(irq_ms), .irq_err(irq_err)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Expected line vector {err,ms,rto,tx,rx,any} from a masked value
  function automatic logic [5:0] lines_of(input logic [10:0] m);
    logic [5:0] r;
    r[0] = m != 0;
    r[1] = m[4];
    r[2] = m[5];
    r[3] = m[6];
    r[4] = m[0] | m[1] | m[2] | m[3];
    r[5] = m[7] | m[8] | m[9] | m[10];
    return r;
  endfunction

  function automatic logic [5:0] lines_now();
    return {irq_err, irq_ms, irq_rto, irq_tx, irq_rx, irq_any};
  endfunction

  task automatic reg_write(input logic [3:0] a, input logic [10:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic reg_read(input logic [3:0] a, output logic [10:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    #1 d = rsp_rdata;
    req_valid = 1'b0;
  endtask

  task automatic drive_src(input int idx, input logic v);
    if (idx < 4)       ms_evt[idx] = v;
    else if (idx == 4) rx_evt = v;
    else if (idx == 5) tx_evt = v;
    else if (idx == 6) rto_evt = v;
    else               err_evt[idx-7] = v;
  endtask

  task automatic pulse(input int idx);
    @(negedge clk);
    drive_src(idx, 1'b1);
    @(negedge clk);
    drive_src(idx, 1'b0);
    exp_raw[idx] = 1'b1;
  endtask

  task automatic settle();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic t_reset();
    logic [10:0] d;
    reg_read(4'd0, d); chk(d == 0, "R1 raw", d, 0);
    reg_read(4'd2, d); chk(d == 0, "R1 mask", d, 0);
    reg_read(4'd1, d); chk(d == 0, "R1 masked", d, 0);
    chk(lines_now() == 0, "R1 lines", lines_now(), 0);
  endtask

  task automatic t_set_map();
    logic [10:0] d;
    for (int i = 0; i < 11; i++) begin
      pulse(i);
      reg_read(4'd0, d);
      chk(d == exp_raw, $sformatf("R2 R11 src%0d", i), d, exp_raw);
    end
    chk(lines_now() == 0, "R6 masked off lines", lines_now(), 0);
    reg_write(4'd3, 11'h7FF); exp_raw = '0;
    reg_read(4'd0, d); chk(d == 0, "R3 clear all", d, 0);
  endtask

  task automatic t_mask();
    logic [10:0] d;
    reg_write(4'd2, 11'h5A5); exp_mask = 11'h5A5;
    reg_read(4'd2, d); chk(d == exp_mask, "R5 readback", d, exp_mask);
    reg_write(4'd2, 11'h2C3); exp_mask = 11'h2C3;
    reg_read(4'd2, d); chk(d == exp_mask, "R5 readback2", d, exp_mask);
    pulse(0); pulse(4); pulse(9); pulse(10);
    reg_read(4'd1, d); chk(d == (exp_raw & exp_mask), "R6 masked", d, exp_raw & exp_mask);
    reg_write(4'd0, 11'h000);
    reg_write(4'd1, 11'h7FF);
    reg_read(4'd0, d); chk(d == exp_raw, "R10 raw unchanged", d, exp_raw);
    reg_read(4'd2, d); chk(d == exp_mask, "R10 mask unchanged", d, exp_mask);
    reg_write(4'd3, 11'h7FF); exp_raw = '0;
  endtask

  task automatic t_lines();
    logic [5:0] e;
    reg_write(4'd2, 11'h7FF); exp_mask = 11'h7FF;
    for (int i = 0; i < 11; i++) begin
      @(negedge clk); drive_src(i, 1'b1);
      @(negedge clk); drive_src(i, 1'b0); exp_raw[i] = 1'b1;
      chk(lines_now() == 0, $sformatf("R9 old level src%0d", i), lines_now(), 0);
      settle();
      e = lines_of(exp_raw & exp_mask);
      chk(lines_now() == e, $sformatf("R7 R8 src%0d", i), lines_now(), e);
      reg_write(4'd3, 11'h7FF); exp_raw = '0;
      settle();
      chk(lines_now() == 0, $sformatf("R3 lines cleared src%0d", i), lines_now(), 0);
    end
    pulse(8); pulse(2); settle();
    reg_write(4'd2, 11'h004); exp_mask = 11'h004;
    e = lines_of(exp_raw & 11'h7FF);
    chk(lines_now() == e, "R9 mask change one cycle late", lines_now(), e);
    settle();
    e = lines_of(exp_raw & exp_mask);
    chk(lines_now() == e, "R8 mask change applied", lines_now(), e);
    reg_write(4'd3, 11'h7FF); exp_raw = '0;
  endtask

  task automatic t_clear_partial();
    logic [10:0] d;
    pulse(1); pulse(5); pulse(7); pulse(10);
    reg_write(4'd3, 11'h0A2); exp_raw = exp_raw & ~11'h0A2;
    reg_read(4'd0, d); chk(d == exp_raw, "R3 partial clear", d, exp_raw);
    reg_write(4'd3, 11'h7FF); exp_raw = '0;
  endtask

  task automatic t_set_wins();
    logic [10:0] d;
    pulse(6);
    @(negedge clk);
    err_evt[2] = 1'b1; rx_evt = 1'b1;
    req_valid = 1'b1; req_write = 1'b1; req_addr = 4'd3; req_wdata = 11'h650;
    @(negedge clk);
    err_evt[2] = 1'b0; rx_evt = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    exp_raw = 11'h210;
    reg_read(4'd0, d); chk(d == exp_raw, "R4 set wins", d, exp_raw);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_set_map();
    t_mask();
    t_lines();
    t_clear_partial();
    t_set_wins();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    checks++; errors++;
    $display("FAIL watchdog expired actual=0x1 expected=0x0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule